// File: doc/BRIEF.md
# Privileged Interrupt Entry Sequencer

This block is the trap unit of a small processor. At every instruction boundary it looks at the instruction being offered, any fault that instruction raised, and the level of the hardware interrupt line. From these it picks one event. Software interrupts, processor faults and external interrupts all take the same entry path. The entry path is an uninterruptible micro-sequence:

- push the flags word onto a memory stack;
- push the return address;
- raise supervisor mode and mask interrupts;
- fetch the handler address from a vector table held in the same memory;
- hand that address to the fetch unit.

A return instruction pops both words back. Privilege lives in the saved flags word, so a return alone drops a handler back to user mode when it was entered from user mode.

The sequencer also enforces privilege. In user mode, masking interrupts, writing the vector table or returning from a handler all become a general protection fault instead of being carried out. The core must stall while `busy_o` is high and must resume fetching at `pc_o` when `pc_load_o` pulses. The memory has one port, and read data returns one cycle after the request.

Top module: `trap_seq`

## Requirements
- R1: After reset the unit is in supervisor mode with interrupts masked and idle, and the first push of the stack goes to address 2^ADDR_W-1.
- R2: On an entry accepted at boundary cycle T, the following happens, and the unit is busy throughout:
  - cycle T+1 writes the flags word to SP-1, with bit 1 = supervisor, bit 0 = interrupt enable, and the other bits zero;
  - cycle T+2 writes the return address to SP-2;
  - cycle T+3 reads address VT_BASE+vector;
  - cycle T+4 pulses `pc_load_o` with the word read.
- R3: The pushed flags word holds the values from before entry. Supervisor becomes 1 and interrupt enable becomes 0 from cycle T+2 onward.
- R4: A software interrupt (op 1) enters at vector `arg_vec_i` with return address `next_pc_i`. A taken hardware interrupt enters at `irq_vec_i` with return address `instr_pc_i`, and the offered instruction is not executed.
- R5: A reported fault enters with return address `instr_pc_i`. Fault code 0 maps to vector 6, 1 to 13, 2 to 14 and 3 to 17.
- R6: Priority at a boundary, highest first: reported fault, then privilege violation, then hardware interrupt, then the offered instruction.
- R7: A hardware interrupt is taken only at a boundary where interrupt enable is 1. Otherwise the instruction proceeds as normal.
- R8: A return (op 2) does the following:
  - cycle T+1 reads SP and cycle T+2 reads SP+1, so SP ends 2 higher;
  - cycle T+3 pulses `pc_load_o` with the first word read;
  - from cycle T+4 the second word sets supervisor (bit 1) and interrupt enable (bit 0).
- R9: In user mode, mask (op 3), vector write (op 5) and return (op 2) are not performed. Each raises vector 13 with return address `instr_pc_i`.
- R10: In supervisor mode, the following ops take effect:
  - op 3 clears interrupt enable and op 4 sets it;
  - op 6 clears supervisor;
  - op 5 writes `arg_data_i` to VT_BASE+`arg_vec_i` in cycle T+1, with busy high.
- R11: A boundary offered while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction boundary strobe |
| op_i | input | 3 | Operation: 0 none, 1 soft interrupt, 2 return, 3 mask, 4 unmask, 5 vector write, 6 drop to user |
| arg_vec_i | input | VEC_W | Vector of a soft interrupt, or index of a vector write |
| arg_data_i | input | DATA_W | Handler address for a vector write |
| instr_pc_i | input | DATA_W | Address of the offered instruction |
| next_pc_i | input | DATA_W | Address of the instruction after it |
| fault_i | input | 1 | The offered instruction faulted |
| fault_code_i | input | 2 | Fault kind |
| irq_i | input | 1 | Hardware interrupt request level |
| irq_vec_i | input | VEC_W | Hardware interrupt vector |
| mem_rdata_i | input | DATA_W | Read data, one cycle after the request |
| busy_o | output | 1 | Sequence in progress; the core stalls |
| pc_load_o | output | 1 | Load `pc_o` into the program counter |
| pc_o | output | DATA_W | New program counter |
| supervisor_o | output | 1 | Current privilege |
| irq_en_o | output | 1 | Current interrupt enable |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Memory write data |

## Verification
The bench goes after the following cases:

- **Privilege escalation.** A user-mode return, mask or vector write is attempted. A design without the check would let user code restore supervisor, silence interrupts, or redirect a handler.
- **Contested boundaries.** A fault arrives while an interrupt is pending, and an interrupt coincides with a soft interrupt. A wrong priority shows up as the wrong vector, or as a return address off by one instruction.
- **Flag timing.** A design that updates the flags before pushing them would save supervisor=1, and the handler would never return to user mode.
- **Nesting.** Nested entries and returns catch stack pointer slips.
- **Boundaries during busy.** A boundary held high throughout a sequence would corrupt the flags if it were accepted.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_SWI  = 3'd1,
    OP_IRET = 3'd2,
    OP_CLI  = 3'd3,
    OP_STI  = 3'd4,
    OP_VTWR = 3'd5,
    OP_USER = 3'd6
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PUSHF, S_PUSHPC, S_VREAD, S_VLOAD,
    S_POPPC, S_POPF, S_RLOAD, S_VTW
  } seq_e;

  localparam int unsigned VEC_INVOP = 6;
  localparam int unsigned VEC_GPF   = 13;
  localparam int unsigned VEC_PGF   = 14;
  localparam int unsigned VEC_ALIGN = 17;

  function automatic int unsigned fault_vector(input logic [1:0] code);
    case (code)
      2'd0:    return VEC_INVOP;
      2'd1:    return VEC_GPF;
      2'd2:    return VEC_PGF;
      default: return VEC_ALIGN;
    endcase
  endfunction
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
#(
  parameter int unsigned VEC_W  = 5,
  parameter int unsigned DATA_W = 16
) (
  input  logic              valid_i,
  input  op_e               op_i,
  input  logic [VEC_W-1:0]  arg_vec_i,
  input  logic [DATA_W-1:0] instr_pc_i,
  input  logic [DATA_W-1:0] next_pc_i,
  input  logic              fault_i,
  input  logic [1:0]        fault_code_i,
  input  logic              irq_i,
  input  logic [VEC_W-1:0]  irq_vec_i,
  input  logic              sup_i,
  input  logic              ie_i,
  output logic              entry_o,
  output logic [VEC_W-1:0]  entry_vec_o,
  output logic [DATA_W-1:0] entry_ret_o,
  output logic              ret_o,
  output logic              cli_o,
  output logic              sti_o,
  output logic              user_o,
  output logic              vtwr_o
);
  logic priv_op, priv_viol, irq_take;

  assign priv_op   = (op_i == OP_CLI) || (op_i == OP_VTWR) || (op_i == OP_IRET);
  assign priv_viol = priv_op && !sup_i;
  assign irq_take  = irq_i && ie_i;

  always_comb begin
    entry_o     = 1'b0;
    entry_vec_o = '0;
    entry_ret_o = instr_pc_i;
    ret_o       = 1'b0;
    cli_o       = 1'b0;
    sti_o       = 1'b0;
    user_o      = 1'b0;
    vtwr_o      = 1'b0;
    if (valid_i) begin
      if (fault_i) begin
        entry_o     = 1'b1;
        entry_vec_o = VEC_W'(fault_vector(fault_code_i));
      end else if (priv_viol) begin
        entry_o     = 1'b1;
        entry_vec_o = VEC_W'(VEC_GPF);
      end else if (irq_take) begin
        entry_o     = 1'b1;
        entry_vec_o = irq_vec_i;
      end else begin
        case (op_i)
          OP_SWI: begin
            entry_o     = 1'b1;
            entry_vec_o = arg_vec_i;
            entry_ret_o = next_pc_i;
          end
          OP_IRET: ret_o  = 1'b1;
          OP_CLI:  cli_o  = 1'b1;
          OP_STI:  sti_o  = 1'b1;
          OP_USER: user_o = 1'b1;
          OP_VTWR: vtwr_o = 1'b1;
          default: ;
        endcase
      end
    end
  end

  // R6: at most one action per boundary
  always_comb begin
    a_r6_one_action: assert ($onehot0({entry_o, ret_o, cli_o, sti_o, user_o, vtwr_o}))
      else $error("arbiter chose more than one action");
  end
endmodule

// File: rtl/trap_flags.sv
module trap_flags #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enter_i,
  input  logic              restore_i,
  input  logic [DATA_W-1:0] restore_word_i,
  input  logic              cli_i,
  input  logic              sti_i,
  input  logic              user_i,
  output logic              sup_o,
  output logic              ie_o,
  output logic [DATA_W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sup_o <= 1'b1;
      ie_o  <= 1'b0;
    end else if (enter_i) begin
      sup_o <= 1'b1;
      ie_o  <= 1'b0;
    end else if (restore_i) begin
      sup_o <= restore_word_i[1];
      ie_o  <= restore_word_i[0];
    end else begin
      if (cli_i)  ie_o  <= 1'b0;
      if (sti_i)  ie_o  <= 1'b1;
      if (user_i) sup_o <= 1'b0;
    end
  end

  assign word_o = {{(DATA_W-2){1'b0}}, sup_o, ie_o};

  a_r3_entry_privileged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_i |=> sup_o && !ie_o);
  a_r8_restore_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |=> (sup_o == $past(restore_word_i[1])) && (ie_o == $past(restore_word_i[0])));
endmodule

// File: rtl/trap_stack_seq.sv
module trap_stack_seq
  import trap_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned VEC_W   = 5,
  parameter int unsigned VT_BASE = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              entry_i,
  input  logic [VEC_W-1:0]  entry_vec_i,
  input  logic [DATA_W-1:0] entry_ret_i,
  input  logic              ret_i,
  input  logic              vtwr_i,
  input  logic [VEC_W-1:0]  vt_idx_i,
  input  logic [DATA_W-1:0] vt_data_i,
  input  logic [DATA_W-1:0] flags_word_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              enter_o,
  output logic              restore_o,
  output logic [DATA_W-1:0] restore_word_o,
  output logic              pc_load_o,
  output logic [DATA_W-1:0] pc_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  localparam logic [ADDR_W-1:0] VT_ADDR = ADDR_W'(VT_BASE);

  seq_e              state_q;
  logic [ADDR_W-1:0] sp_q;
  logic [VEC_W-1:0]  vec_q;
  logic [DATA_W-1:0] word_q;
  logic [ADDR_W-1:0] vt_slot;

  assign vt_slot = VT_ADDR + ADDR_W'(vec_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      sp_q    <= '0;
      vec_q   <= '0;
      word_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (entry_i) begin
            vec_q   <= entry_vec_i;
            word_q  <= entry_ret_i;
            state_q <= S_PUSHF;
          end else if (ret_i) begin
            state_q <= S_POPPC;
          end else if (vtwr_i) begin
            vec_q   <= vt_idx_i;
            word_q  <= vt_data_i;
            state_q <= S_VTW;
          end
        end
        S_PUSHF:  begin sp_q <= sp_q - 1'b1; state_q <= S_PUSHPC; end
        S_PUSHPC: begin sp_q <= sp_q - 1'b1; state_q <= S_VREAD;  end
        S_VREAD:  state_q <= S_VLOAD;
        S_POPPC:  begin sp_q <= sp_q + 1'b1; state_q <= S_POPF;   end
        S_POPF: begin
          sp_q    <= sp_q + 1'b1;
          word_q  <= mem_rdata_i;
          state_q <= S_RLOAD;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = sp_q;
    mem_wdata_o = '0;
    pc_load_o   = 1'b0;
    pc_o        = '0;
    case (state_q)
      S_PUSHF: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = sp_q - 1'b1; mem_wdata_o = flags_word_i;
      end
      S_PUSHPC: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = sp_q - 1'b1; mem_wdata_o = word_q;
      end
      S_VREAD: begin mem_req_o = 1'b1; mem_addr_o = vt_slot; end
      S_VLOAD: begin pc_load_o = 1'b1; pc_o = mem_rdata_i; end
      S_POPPC, S_POPF: mem_req_o = 1'b1;
      S_RLOAD: begin pc_load_o = 1'b1; pc_o = word_q; end
      S_VTW: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = vt_slot; mem_wdata_o = word_q;
      end
      default: ;
    endcase
  end

  assign busy_o         = (state_q != S_IDLE);
  assign enter_o        = (state_q == S_PUSHF);
  assign restore_o      = (state_q == S_RLOAD);
  assign restore_word_o = mem_rdata_i;

  a_r2_push_descends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PUSHPC) |-> mem_we_o && (mem_addr_o == $past(mem_addr_o) - 1'b1));
  a_r8_pop_ascends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_POPF) |-> !mem_we_o && (mem_addr_o == $past(mem_addr_o) + 1'b1));
  a_r11_load_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |-> busy_o && $past(busy_o));
endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import trap_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned VEC_W   = 5,
  parameter int unsigned VT_BASE = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_valid_i,
  input  logic [2:0]        op_i,
  input  logic [VEC_W-1:0]  arg_vec_i,
  input  logic [DATA_W-1:0] arg_data_i,
  input  logic [DATA_W-1:0] instr_pc_i,
  input  logic [DATA_W-1:0] next_pc_i,
  input  logic              fault_i,
  input  logic [1:0]        fault_code_i,
  input  logic              irq_i,
  input  logic [VEC_W-1:0]  irq_vec_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              pc_load_o,
  output logic [DATA_W-1:0] pc_o,
  output logic              supervisor_o,
  output logic              irq_en_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  logic              entry, ret, cli, sti, usr, vtwr, enter, restore;
  logic [VEC_W-1:0]  entry_vec;
  logic [DATA_W-1:0] entry_ret, flags_word, restore_word;
  logic              boundary;

  assign boundary = instr_valid_i && !busy_o;

  trap_arbiter #(.VEC_W(VEC_W), .DATA_W(DATA_W)) u_arb (
    .valid_i(boundary), .op_i(op_e'(op_i)), .arg_vec_i(arg_vec_i),
    .instr_pc_i(instr_pc_i), .next_pc_i(next_pc_i),
    .fault_i(fault_i), .fault_code_i(fault_code_i),
    .irq_i(irq_i), .irq_vec_i(irq_vec_i),
    .sup_i(supervisor_o), .ie_i(irq_en_o),
    .entry_o(entry), .entry_vec_o(entry_vec), .entry_ret_o(entry_ret),
    .ret_o(ret), .cli_o(cli), .sti_o(sti), .user_o(usr), .vtwr_o(vtwr)
  );

  trap_flags #(.DATA_W(DATA_W)) u_flags (
    .clk_i, .rst_ni, .enter_i(enter), .restore_i(restore),
    .restore_word_i(restore_word), .cli_i(cli), .sti_i(sti), .user_i(usr),
    .sup_o(supervisor_o), .ie_o(irq_en_o), .word_o(flags_word)
  );

  trap_stack_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W),
                   .VT_BASE(VT_BASE)) u_seq (
    .clk_i, .rst_ni, .entry_i(entry), .entry_vec_i(entry_vec),
    .entry_ret_i(entry_ret), .ret_i(ret), .vtwr_i(vtwr),
    .vt_idx_i(arg_vec_i), .vt_data_i(arg_data_i), .flags_word_i(flags_word),
    .mem_rdata_i, .busy_o, .enter_o(enter), .restore_o(restore),
    .restore_word_o(restore_word), .pc_load_o, .pc_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o
  );

  a_r9_user_mask_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary && !supervisor_o && !fault_i && op_i == 3'(OP_CLI)) |=> busy_o && $stable(irq_en_o));
  a_r7_masked_irq_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary && irq_i && !irq_en_o && !fault_i && op_i == 3'(OP_NOP)) |=> !busy_o);
  a_r11_busy_no_flag_ops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !pc_load_o && !enter) |=> $stable(supervisor_o));
endmodule

// File: tb/trap_seq_bench.sv
module trap_seq_bench;
  import trap_pkg::*;

  localparam int AW = 8, DW = 16, VW = 5;

  typedef struct {
    bit req, we, pcl, sup, ie;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata, pc;
    string tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic instr_valid = 0, fault = 0, irq = 0;
  logic [2:0] op = 0;
  logic [VW-1:0] arg_vec = 0, irq_vec = 0;
  logic [DW-1:0] arg_data = 0, ipc = 0, npc = 0, rdata;
  logic [1:0] fcode = 0;
  logic busy, pcl, sup, ie, req, we;
  logic [DW-1:0] pc, wdata;
  logic [AW-1:0] addr;

  always #4 clk = ~clk;

  trap_seq #(.ADDR_W(AW), .DATA_W(DW), .VEC_W(VW), .VT_BASE(0)) u_trap_seq (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(instr_valid), .op_i(op),
    .arg_vec_i(arg_vec), .arg_data_i(arg_data), .instr_pc_i(ipc), .next_pc_i(npc),
    .fault_i(fault), .fault_code_i(fcode), .irq_i(irq), .irq_vec_i(irq_vec),
    .mem_rdata_i(rdata), .busy_o(busy), .pc_load_o(pcl), .pc_o(pc),
    .supervisor_o(sup), .irq_en_o(ie), .mem_req_o(req), .mem_we_o(we),
    .mem_addr_o(addr), .mem_wdata_o(wdata)
  );

  // bench memory
  logic [DW-1:0] ram [0:(1<<AW)-1];
  initial begin
    for (int i = 0; i < (1<<AW); i++) ram[i] = '0;
    rdata = '0;
  end
  always @(posedge clk) begin
    if (req && we) ram[addr] <= wdata;
    else if (req) rdata <= ram[addr];
  end

  // reference model
  bit msup, mie;
  logic [AW-1:0] msp;
  logic [DW-1:0] mref [0:(1<<AW)-1];
  exp_t q[$];
  int vectors = 0, fails = 0;
  bit done = 0;

  function automatic void push_exp(bit r, bit w, logic [AW-1:0] a, logic [DW-1:0] d,
                                   bit l, logic [DW-1:0] p, string t);
    exp_t e;
    e.req = r; e.we = w; e.addr = a; e.wdata = d; e.pcl = l; e.pc = p;
    e.sup = msup; e.ie = mie; e.tag = t;
    q.push_back(e);
  endfunction

  function automatic int unsigned fvec(logic [1:0] c);
    case (c) 2'd0: return 6; 2'd1: return 13; 2'd2: return 14; default: return 17; endcase
  endfunction

  function automatic void model_entry(int unsigned v, logic [DW-1:0] ret, string t);
    logic [DW-1:0] fw;
    fw = {14'd0, msup, mie};
    push_exp(1, 1, msp - 1'b1, fw, 0, '0, "R2");      // flags first, old values (R3)
    mref[msp - 1'b1] = fw; msp = msp - 1'b1;
    msup = 1; mie = 0;
    push_exp(1, 1, msp - 1'b1, ret, 0, '0, "R3");
    mref[msp - 1'b1] = ret; msp = msp - 1'b1;
    push_exp(1, 0, AW'(v), '0, 0, '0, "R2");
    push_exp(0, 0, '0, '0, 1, mref[AW'(v)], t);
  endfunction

  function automatic void model_boundary();
    bit priv;
    priv = (op == 3'(OP_CLI)) || (op == 3'(OP_VTWR)) || (op == 3'(OP_IRET));
    if (fault) model_entry(fvec(fcode), ipc, "R5");
    else if (!msup && priv) model_entry(13, ipc, "R9");
    else if (irq && mie) model_entry(irq_vec, ipc, "R6");
    else case (op)
      3'(OP_SWI): model_entry(arg_vec, npc, "R4");
      3'(OP_IRET): begin
        logic [DW-1:0] r, f;
        push_exp(1, 0, msp, '0, 0, '0, "R8"); r = mref[msp]; msp = msp + 1'b1;
        push_exp(1, 0, msp, '0, 0, '0, "R8"); f = mref[msp]; msp = msp + 1'b1;
        push_exp(0, 0, '0, '0, 1, r, "R8");
        msup = f[1]; mie = f[0];
      end
      3'(OP_CLI):  mie = 0;
      3'(OP_STI):  mie = 1;
      3'(OP_USER): msup = 0;
      3'(OP_VTWR): begin
        push_exp(1, 1, AW'(arg_vec), arg_data, 0, '0, "R10");
        mref[AW'(arg_vec)] = arg_data;
      end
      default: ;
    endcase
  endfunction

  task automatic cyc();
    exp_t e;
    bit bad;
    @(negedge clk);
    if (done) return;
    if (q.size() > 0) e = q.pop_front();
    else begin
      e.req = 0; e.we = 0; e.pcl = 0; e.addr = '0; e.wdata = '0; e.pc = '0;
      e.sup = msup; e.ie = mie; e.tag = "R11";
    end
    vectors++;
    bad = (busy !== (e.req | e.pcl)) || (req !== e.req) || (pcl !== e.pcl) ||
          (sup !== e.sup) || (ie !== e.ie) ||
          (e.req && ((we !== e.we) || (addr !== e.addr) || (e.we && wdata !== e.wdata))) ||
          (e.pcl && pc !== e.pc);
    if (bad) begin
      fails++;
      $display("FAIL %s: got busy=%b req=%b we=%b addr=%h wd=%h pcl=%b pc=%h sup=%b ie=%b ; exp req=%b we=%b addr=%h wd=%h pcl=%b pc=%h sup=%b ie=%b",
               e.tag, busy, req, we, addr, wdata, pcl, pc, sup, ie,
               e.req, e.we, e.addr, e.wdata, e.pcl, e.pc, e.sup, e.ie);
    end
  endtask

  task automatic instr(logic [2:0] o, logic [VW-1:0] v, logic [DW-1:0] d,
                       logic [DW-1:0] p, bit f, logic [1:0] fc, bit hold);
    op = o; arg_vec = v; arg_data = d; ipc = p; npc = p + 1; fault = f; fcode = fc;
    instr_valid = 1;
    model_boundary();
    cyc();
    if (hold) op = 3'(OP_STI);     // R11: boundary presented while busy
    else instr_valid = 0;
    while (q.size() > 0) cyc();
    instr_valid = 0; fault = 0;
    cyc();
  endtask

  initial begin
    msup = 1; mie = 0; msp = '0;
    for (int i = 0; i < (1<<AW); i++) mref[i] = '0;
    #20 rst_n = 1;
    for (int i = 0; i < 3; i++) cyc();            // R1 reset state
    // R10 vector table setup in supervisor mode
    instr(3'(OP_VTWR), 5'd6,  16'h0600, 16'h0010, 0, 0, 0);
    instr(3'(OP_VTWR), 5'd13, 16'h0D00, 16'h0011, 0, 0, 0);
    instr(3'(OP_VTWR), 5'd14, 16'h0E00, 16'h0012, 0, 0, 0);
    instr(3'(OP_VTWR), 5'd17, 16'h1100, 16'h0013, 0, 0, 0);
    instr(3'(OP_VTWR), 5'd3,  16'h0300, 16'h0014, 0, 0, 0);
    instr(3'(OP_VTWR), 5'd9,  16'h0900, 16'h0015, 0, 0, 0);
    instr(3'(OP_STI),  5'd0,  16'h0,    16'h0016, 0, 0, 0); // R10 unmask
    // R4 soft interrupt from supervisor, R8 return
    instr(3'(OP_SWI),  5'd3,  16'h0,    16'h0020, 0, 0, 0);
    instr(3'(OP_SWI),  5'd3,  16'h0,    16'h0300, 0, 0, 0); // nested R2
    instr(3'(OP_IRET), 5'd0,  16'h0,    16'h0301, 0, 0, 0);
    instr(3'(OP_IRET), 5'd0,  16'h0,    16'h0302, 0, 0, 0);
    instr(3'(OP_CLI),  5'd0,  16'h0,    16'h0021, 0, 0, 0); // R10 mask
    instr(3'(OP_STI),  5'd0,  16'h0,    16'h0022, 0, 0, 0);
    instr(3'(OP_USER), 5'd0,  16'h0,    16'h0023, 0, 0, 0); // drop to user
    // R8 user -> handler -> user, R11 boundary held while busy
    instr(3'(OP_SWI),  5'd3,  16'h0,    16'h0040, 0, 0, 1);
    instr(3'(OP_IRET), 5'd0,  16'h0,    16'h0303, 0, 0, 0);
    // R9 privileged ops in user mode
    instr(3'(OP_CLI),  5'd0,  16'h0,    16'h0050, 0, 0, 0);
    instr(3'(OP_IRET), 5'd0,  16'h0,    16'h0D00, 0, 0, 0);
    instr(3'(OP_VTWR), 5'd3,  16'hBEEF, 16'h0051, 0, 0, 0);
    instr(3'(OP_IRET), 5'd0,  16'h0,    16'h0D01, 0, 0, 0);
    instr(3'(OP_IRET), 5'd0,  16'h0,    16'h0052, 0, 0, 0); // user return -> GP
    instr(3'(OP_IRET), 5'd0,  16'h0,    16'h0D02, 0, 0, 0);
    instr(3'(OP_SWI),  5'd3,  16'h0,    16'h0053, 0, 0, 0); // R9 table untouched
    instr(3'(OP_IRET), 5'd0,  16'h0,    16'h0303, 0, 0, 0);
    // R6 fault beats pending IRQ; R7 IRQ taken after return restores enable
    irq = 1; irq_vec = 5'd9;
    instr(3'(OP_NOP),  5'd0,  16'h0,    16'h0060, 1, 2'd2, 0);
    instr(3'(OP_NOP),  5'd0,  16'h0,    16'h0E00, 0, 0, 0); // R7 masked in handler
    instr(3'(OP_IRET), 5'd0,  16'h0,    16'h0E01, 0, 0, 0);
    instr(3'(OP_SWI),  5'd3,  16'h0,    16'h0060, 0, 0, 0); // R6 IRQ beats soft interrupt
    irq = 0;
    instr(3'(OP_IRET), 5'd0,  16'h0,    16'h0900, 0, 0, 0);
    // R5 fault codes
    for (int c = 0; c < 4; c++) begin
      instr(3'(OP_NOP),  5'd0, 16'h0, 16'h0070 + 16'(c), 1, 2'(c), 0);
      instr(3'(OP_IRET), 5'd0, 16'h0, 16'h0A00, 0, 0, 0);
    end
    for (int i = 0; i < 2; i++) cyc();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule